// File: doc/BRIEF.md
# Coarse Cascaded Delay Search Controller

This controller finds the coarse arrival time of a single photon relative to a sync pulse. It does this by stepping a pair of cascaded coarse delay lines until the receiver reports that the photon lands inside its narrow detection window. Once an initialisation phase has finished, each trigger pulse opens a trial. The trial is a hit when the receiver raises both of its window-valid flags before a timeout, and a miss otherwise.

Hits and misses are counted as consecutive streaks. A run of misses moves the delay one step later. The first line is advanced until it saturates, and only after that is the second line advanced. A run of hits ends the search and keeps the codes found. If a step is needed while both lines are saturated, the search stops with an error. Every new code pair is announced with a one-cycle write strobe and is then left to settle for a few cycles, during which no trial can start.

Top module: `coarse_delay_search`

## Requirements
- R1: After reset both codes are 0, and `code_wr`, `done`, `err` and all bits of `err_leds` are 0.
- R2: A trigger opens a trial only when `init_done` is 1, no trial or settle period is in progress, and neither `done` nor `err` is set. All other triggers have no effect.
- R3: A trial is a hit if `win_a` and `win_b` are both 1 on one of the first TIMEOUT (default 60) clock edges after the trigger edge. If the window flags stay low, only one of them rises, or they rise later than that, the trial is a miss.
- R4: Streaks are consecutive. A hit clears the miss count, a miss clears the hit count, and both counts clear when the delay steps.
- R5: The STREAK-th (default 5) consecutive hit sets `done`, and both codes keep their values.
- R6: The STREAK-th consecutive miss steps the delay. `code_a` increments while it is below SAT_CODE (default 0x0FF). Otherwise `code_b` increments.
- R7: A step that is requested while both codes equal SAT_CODE sets `err` and leaves the codes unchanged.
- R8: `code_wr` is a one-cycle pulse in the first cycle that shows the new codes, and the codes change only in such a cycle. For HOLD_CYC (default 3) cycles after a step, triggers are ignored.
- R9: Every bit of `err_leds` (LED_N bits, default 4) is 1 while `err` is 1, and 0 otherwise.
- R10: `done` and `err` never both become 1. Each of them holds until reset, and later triggers change neither code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Initialisation finished; search may run |
| trig | input | 1 | Photon trigger pulse, opens a trial |
| win_a | input | 1 | Window-valid flag, first receiver channel |
| win_b | input | 1 | Window-valid flag, second receiver channel |
| code_a | output | CODE_W | Code for the first coarse delay line |
| code_b | output | CODE_W | Code for the second coarse delay line |
| code_wr | output | 1 | One-cycle strobe when a new code pair is presented |
| done | output | 1 | Photon found inside the window; search ended |
| err | output | 1 | Both lines exhausted; search stopped |
| err_leds | output | LED_N | Error indicator vector, all ones on error |

## Verification
The bench places window flags on the last edge that still counts and on the first edge that is too late. A design whose timeout is off by one would take the wrong one of these two trials as a hit. It inserts misses and partial-flag trials into hit runs, and hits into miss runs, so a design that counts totals rather than streaks would finish or step too early. It sends a trigger during the settle period after a step and then makes sure the next four misses cause no step; a design that accepted that trigger would step one trial early. A second instance with a low saturation code walks through the line hand-over and into the error, and the default instance crosses from the first line to the second at 0x0FF, which exposes any wrong saturation compare or order of the two lines.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRIAL = 3'd1,
    ST_STEP  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4,
    ST_ERR   = 3'd5
  } srch_state_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } line_sel_e;

  // The first line takes steps until it is saturated; after that the second line does.
  function automatic line_sel_e pick_line(input logic a_sat, input logic b_sat);
    if (!a_sat)      return SEL_A;
    else if (!b_sat) return SEL_B;
    else             return SEL_NONE;
  endfunction

endpackage

// File: rtl/cds_trial_timer.sv
module cds_trial_timer #(
  parameter int TIMEOUT = 60,
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [TW-1:0] cnt,
  output logic          expired
);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cds_streak.sv
module cds_streak #(
  parameter int STREAK = 5,
  localparam int SW = $clog2(STREAK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_ev,
  input  logic miss_ev,
  input  logic clr,
  output logic hit_last,
  output logic miss_last
);
  localparam logic [SW-1:0] FINAL = SW'(STREAK - 1);

  logic [SW-1:0] hit_cnt, miss_cnt;

  assign hit_last  = hit_ev  && (hit_cnt  == FINAL);
  assign miss_last = miss_ev && (miss_cnt == FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (hit_ev) begin
      hit_cnt  <= hit_cnt + 1'b1;
      miss_cnt <= '0;
    end else if (miss_ev) begin
      miss_cnt <= miss_cnt + 1'b1;
      hit_cnt  <= '0;
    end
  end
endmodule

// File: rtl/cds_cascade.sv
module cds_cascade
  import cds_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int SAT_CODE = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              wr,
  output logic              exhausted
);
  localparam logic [CODE_W-1:0] SAT = CODE_W'(SAT_CODE);

  line_sel_e sel;
  assign sel       = pick_line(code_a >= SAT, code_b >= SAT);
  assign exhausted = (sel == SEL_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
      wr     <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (step) begin
        case (sel)
          SEL_A: begin code_a <= code_a + 1'b1; wr <= 1'b1; end
          SEL_B: begin code_b <= code_b + 1'b1; wr <= 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/coarse_delay_search.sv
module coarse_delay_search
  import cds_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int SAT_CODE = 255,
  parameter int TIMEOUT  = 60,
  parameter int STREAK   = 5,
  parameter int HOLD_CYC = 3,
  parameter int LED_N    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              trig,
  input  logic              win_a,
  input  logic              win_b,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              code_wr,
  output logic              done,
  output logic              err,
  output logic [LED_N-1:0]  err_leds
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  srch_state_e state_q, state_d;

  // Named internal events, also seen by the bound checker
  logic          trial_start, in_trial, both_valid, timeout;
  logic          hit_ev, miss_ev, hit_last, miss_last;
  logic          step_req, exhausted, hold_last;
  logic [TW-1:0] trial_cnt;
  logic [HW-1:0] hold_cnt;

  assign trial_start = (state_q == ST_IDLE) && init_done && trig;
  assign in_trial    = (state_q == ST_TRIAL);
  assign both_valid  = win_a && win_b;
  assign hit_ev      = in_trial && both_valid;
  assign miss_ev     = in_trial && !both_valid && timeout;
  assign step_req    = (state_q == ST_STEP);
  assign hold_last   = (state_q == ST_HOLD) && (hold_cnt == HOLD_LAST);

  cds_trial_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_trial), .cnt(trial_cnt), .expired(timeout)
  );

  cds_streak #(.STREAK(STREAK)) u_streak (
    .clk(clk), .rst_n(rst_n), .hit_ev(hit_ev), .miss_ev(miss_ev),
    .clr(step_req), .hit_last(hit_last), .miss_last(miss_last)
  );

  cds_cascade #(.CODE_W(CODE_W), .SAT_CODE(SAT_CODE)) u_cascade (
    .clk(clk), .rst_n(rst_n), .step(step_req), .code_a(code_a),
    .code_b(code_b), .wr(code_wr), .exhausted(exhausted)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (trial_start) state_d = ST_TRIAL;
      ST_TRIAL: begin
        if (hit_ev)       state_d = hit_last  ? ST_DONE : ST_IDLE;
        else if (miss_ev) state_d = miss_last ? ST_STEP : ST_IDLE;
      end
      ST_STEP:  state_d = exhausted ? ST_ERR : ST_HOLD;
      ST_HOLD:  if (hold_last) state_d = ST_IDLE;
      ST_DONE:  state_d = ST_DONE;
      ST_ERR:   state_d = ST_ERR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_q != ST_HOLD) hold_cnt <= '0;
    else                              hold_cnt <= hold_cnt + 1'b1;
  end

  assign done = (state_q == ST_DONE);
  assign err  = (state_q == ST_ERR);

  for (genvar g = 0; g < LED_N; g++) begin : g_led
    assign err_leds[g] = err;
  end
endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
  parameter int CODE_W   = 10,
  parameter int SAT_CODE = 255,
  parameter int TIMEOUT  = 60,
  parameter int LED_N    = 4,
  parameter int TW       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              code_wr,
  input logic              done,
  input logic              err,
  input logic [LED_N-1:0]  err_leds,
  input logic              trial_start,
  input logic              in_trial,
  input logic [TW-1:0]     trial_cnt
);
  localparam logic [CODE_W-1:0] SAT  = CODE_W'(SAT_CODE);
  localparam logic [TW-1:0]     LAST = TW'(TIMEOUT - 1);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trial_start |-> (init_done && !done && !err));

  assert_trial_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_trial && trial_cnt == LAST) |=> !in_trial);

  assert_frozen_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(code_a) && $stable(code_b)));

  assert_cascade_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_b != $past(code_b)) |-> (code_a == SAT));

  assert_err_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (code_a == SAT && code_b == SAT));

  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> !code_wr);

  assert_code_needs_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_a != $past(code_a)) || (code_b != $past(code_b))) |-> code_wr);

  assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |-> !trial_start);

  assert_leds_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (&err_leds));

  assert_leds_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (err_leds == '0));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind coarse_delay_search cds_checker #(
  .CODE_W(CODE_W), .SAT_CODE(SAT_CODE), .TIMEOUT(TIMEOUT), .LED_N(LED_N), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .code_a(code_a),
  .code_b(code_b), .code_wr(code_wr), .done(done), .err(err),
  .err_leds(err_leds), .trial_start(trial_start), .in_trial(in_trial),
  .trial_cnt(trial_cnt)
);

// File: tb/coarse_delay_search_bench.sv
module coarse_delay_search_bench;
  localparam int CW = 10;
  localparam int SAT0 = 255;
  localparam int SAT1 = 3;
  localparam int TMO = 60;
  localparam int STR = 5;
  localparam int LEDS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0;
  logic trig = 1'b0;
  logic win_a = 1'b0;
  logic win_b = 1'b0;

  logic [CW-1:0] ca0, cb0, ca1, cb1;
  logic wr0, wr1, dn0, dn1, er0, er1;
  logic [LEDS-1:0] led0, led1;

  always #4 clk = ~clk;

  coarse_delay_search u_coarse_delay_search (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .trig(trig),
    .win_a(win_a), .win_b(win_b), .code_a(ca0), .code_b(cb0),
    .code_wr(wr0), .done(dn0), .err(er0), .err_leds(led0)
  );

  coarse_delay_search #(.SAT_CODE(SAT1)) u_coarse_delay_search_small (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .trig(trig),
    .win_a(win_a), .win_b(win_b), .code_a(ca1), .code_b(cb1),
    .code_wr(wr1), .done(dn1), .err(er1), .err_leds(led1)
  );

  int total = 0;
  int bad = 0;
  int wcnt [2] = '{0, 0};

  // Reference state per instance
  int ea [2], eb [2], hits [2], miss [2], wexp [2], sat [2];
  bit edn [2], eer [2];

  always @(negedge clk) begin
    if (rst_n && wr0) wcnt[0]++;
    if (rst_n && wr1) wcnt[1]++;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      ea[i] = 0; eb[i] = 0; hits[i] = 0; miss[i] = 0; wexp[i] = 0;
      edn[i] = 0; eer[i] = 0;
    end
    sat[0] = SAT0; sat[1] = SAT1;
  endfunction

  // Requirement-level model of one accepted trial
  function automatic void model_trial(input bit hit);
    for (int i = 0; i < 2; i++) begin
      if (!edn[i] && !eer[i]) begin
        if (hit) begin
          miss[i] = 0;
          hits[i]++;
          if (hits[i] == STR) edn[i] = 1;
        end else begin
          hits[i] = 0;
          miss[i]++;
          if (miss[i] == STR) begin
            miss[i] = 0;
            if (ea[i] < sat[i]) begin ea[i]++; wexp[i]++; end
            else if (eb[i] < sat[i]) begin eb[i]++; wexp[i]++; end
            else eer[i] = 1;
          end
        end
      end
    end
  endfunction

  task automatic check_all(input string req);
    chk(req, "code_a[0]", int'(ca0), ea[0]);
    chk(req, "code_b[0]", int'(cb0), eb[0]);
    chk(req, "done[0]", int'(dn0), int'(edn[0]));
    chk(req, "err[0]", int'(er0), int'(eer[0]));
    chk(req, "code_a[1]", int'(ca1), ea[1]);
    chk(req, "code_b[1]", int'(cb1), eb[1]);
    chk(req, "done[1]", int'(dn1), int'(edn[1]));
    chk(req, "err[1]", int'(er1), int'(eer[1]));
    chk("R8", "write pulses[0]", wcnt[0], wexp[0]);
    chk("R8", "write pulses[1]", wcnt[1], wexp[1]);
    chk("R9", "leds[0]", int'(led0), eer[0] ? 15 : 0);
    chk("R9", "leds[1]", int'(led1), eer[1] ? 15 : 0);
  endtask

  // kind: 0 both flags at lat, 1 no flag, 2 one flag at lat, 3 both flags at lat (late)
  task automatic do_trial(input int kind, input int lat, input bit poke);
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    for (int k = 1; k <= 72; k++) begin
      if (k == lat) begin
        if (kind == 0 || kind == 3) begin win_a = 1'b1; win_b = 1'b1; end
        else if (kind == 2) begin
          if (lat[0]) win_a = 1'b1; else win_b = 1'b1;
        end
      end
      if (k == lat + 1) begin win_a = 1'b0; win_b = 1'b0; end
      if (poke && k == 62) trig = 1'b1;
      if (poke && k == 63) trig = 1'b0;
      @(negedge clk);
    end
    win_a = 1'b0; win_b = 1'b0; trig = 1'b0;
    if (init_done) model_trial(kind == 0);
  endtask

  initial begin
    void'($urandom(32'h1cd5_7a03));
    model_reset();
    repeat (4) @(negedge clk);
    check_all("R1");
    chk("R1", "code_wr", int'(wr0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: triggers before init_done have no effect
    for (int t = 0; t < STR; t++) do_trial(1, 0, 0);
    check_all("R2");
    init_done = 1'b1;

    // R3/R4: hits on edge 1, 20, last counted edge, then a late flag is a miss
    do_trial(0, 1, 0);  do_trial(0, 20, 0);
    do_trial(0, TMO, 0); do_trial(0, 30, 0);
    check_all("R3");
    do_trial(3, TMO + 1, 0);
    check_all("R4");
    for (int t = 0; t < STR - 1; t++) do_trial(1, 0, 0);
    check_all("R6");

    // R8: trigger during settle period is ignored
    for (int t = 0; t < STR - 1; t++) do_trial(1, 0, 0);
    do_trial(1, 0, 1);
    check_all("R8");
    for (int t = 0; t < STR - 1; t++) do_trial(1, 0, 0);
    check_all("R8");
    do_trial(1, 0, 0);
    check_all("R6");

    // R4: one-flag trials are misses; a hit breaks the miss streak
    for (int t = 0; t < STR - 1; t++) do_trial(2, 5 + t, 0);
    check_all("R3");
    do_trial(0, 7, 0);
    for (int t = 0; t < STR - 1; t++) do_trial(1, 0, 0);
    check_all("R4");
    do_trial(1, 0, 0);
    check_all("R6");

    // Random mix, never allowing a finishing hit run
    for (int t = 0; t < 60; t++) begin
      int kind, lat;
      kind = $urandom_range(0, 3);
      lat = (kind == 3) ? $urandom_range(TMO + 1, TMO + 6) : $urandom_range(1, TMO);
      if (kind == 0 && ((hits[0] == STR - 1 && !edn[0]) ||
                        (hits[1] == STR - 1 && !edn[1] && !eer[1]))) kind = 1;
      do_trial(kind, lat, 0);
      check_all("R4");
    end

    // R6/R7: walk the default instance past first-line saturation
    while (!(ea[0] == SAT0 && eb[0] >= 2)) begin
      do_trial(1, 0, 0);
      check_all("R6");
    end
    check_all("R7");
    chk("R7", "small err", int'(er1), 1);

    // R5: hit run ends the search
    for (int t = 0; t < STR; t++) do_trial(0, $urandom_range(1, TMO), 0);
    check_all("R5");
    chk("R5", "done", int'(dn0), 1);

    // R10: later trials change nothing
    for (int t = 0; t < STR; t++) do_trial(1, 0, 0);
    do_trial(0, 3, 0);
    check_all("R10");

    summary();
    $finish;
  end
endmodule